// File: doc/BRIEF.md
# Carry-Preserving Decrement Flag Unit

This unit is one execution lane of an integer datapath. It takes an operand, subtracts one from it at a chosen operand size, and returns the result together with a recomputed status-flag word. The one exception is the carry flag, which is copied through from the incoming flag word. Because carry survives, a loop counter can be stepped down between multi-word additions without losing the carry chain.

Operands and flags enter on a valid/ready stream and leave on a second valid/ready stream. A single output register sits between the two. A transfer takes place on a rising clock edge when valid and ready are both high. The input side is ready whenever the output register is empty, or is being emptied in that same cycle. The result therefore appears one cycle after acceptance, and a new operand can be taken on every cycle while the consumer keeps `out_ready` high. When the consumer holds `out_ready` low, the pending result and its flags stay frozen and `in_ready` drops. No input is lost and none is duplicated.

Top module: `dec_flag_unit`

## Requirements
- R1: The low N bits of `out_result` equal the low N bits of the operand minus one, modulo 2^N. N is set by `in_size`: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R2: At size 0 or 1, the result bits above bit N-1 equal the same operand bits. At size 2, result bits 63:32 are zero.
- R3: The flag word is laid out as bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign and bit 5 overflow. Output bit 0 always equals input bit 0.
- R4: Overflow (bit 5) is 1 exactly when the operand's low N bits hold the most negative N-bit value, with only bit N-1 set.
- R5: Sign (bit 4) equals result bit N-1.
- R6: Zero (bit 3) is 1 exactly when the low N bits of the result are all zero.
- R7: Auxiliary carry (bit 2) is 1 exactly when operand bits 3:0 are all zero. This is the case where a borrow crosses out of bit 3.
- R8: Parity (bit 1) is 1 exactly when result bits 7:0 hold an even number of ones, at every size.
- R9: An operand accepted on an edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge. `in_ready` is high when `out_valid` is low or `out_ready` is high, so back-to-back transfers run at one per cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_result` and `out_flags` hold their values and `out_valid` stays high.
- R11: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operand is valid |
| in_ready | output | 1 | Unit can accept an operand |
| in_operand | input | 64 | Value to decrement |
| in_size | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| in_flags | input | 6 | Incoming flag word (layout in R3) |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Decremented value |
| out_flags | output | 6 | Updated flag word |

## Verification
The output register holds all of the unit's internal state, so a wrong internal value reaches the ports on the first cycle after acceptance. It shows up as a wrong result, as a flag that disagrees with the size-truncated result, or as a carry that differs from the carry sent in. A faulty stall path shows as a result that changes while `out_ready` is low, or as a lost or repeated transfer in a back-to-back burst. Both are visible one edge after the fault occurs.

// File: rtl/dec_flag_pkg.sv
package dec_flag_pkg;
  localparam int DATA_W  = 64;
  localparam int NIB_W   = 4;
  localparam int PAR_W   = 8;
  localparam int FLAG_W  = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_FULL = 2'd3
  } opsz_e;

  // bit 5 .. bit 0
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  function automatic int size_bits(opsz_e sz);
    return 8 << sz;
  endfunction
endpackage

// File: rtl/dec_width_mask.sv
module dec_width_mask
  import dec_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  opsz_e         size,
  output logic [W-1:0]  lane_mask,
  output logic [W-1:0]  top_mask
);
  int nbits;

  always_comb begin
    nbits = size_bits(size);
    if (nbits > W) nbits = W;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign lane_mask[i] = (i < nbits);
    assign top_mask[i]  = (i == nbits - 1);
  end
endmodule

// File: rtl/dec_core.sv
module dec_core
  import dec_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] operand,
  input  opsz_e        size,
  input  logic [W-1:0] lane_mask,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] full_dec;
  logic [W-1:0] upper_keep;

  always_comb begin
    full_dec = operand - ONE;
    // 32-bit writes zero the upper half; narrower sizes merge
    if (size == SZ_WORD) upper_keep = '0;
    else                 upper_keep = operand & ~lane_mask;
    result = (full_dec & lane_mask) | upper_keep;
  end
endmodule

// File: rtl/dec_flag_gen.sv
module dec_flag_gen
  import dec_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] operand,
  input  logic [W-1:0] result,
  input  logic [W-1:0] lane_mask,
  input  logic [W-1:0] top_mask,
  input  flags_t       flags_in,
  output flags_t       flags_out
);
  always_comb begin
    flags_out.cry = flags_in.cry;
    flags_out.ovf = ((operand & lane_mask) == top_mask);
    flags_out.sgn = |(result & top_mask);
    flags_out.zro = ~|(result & lane_mask);
    flags_out.aux = ~|operand[NIB_W-1:0];
    flags_out.par = ~^result[PAR_W-1:0];
  end
endmodule

// File: rtl/dec_out_stage.sv
module dec_out_stage
  import dec_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_result,
  input  flags_t       up_flags,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_result,
  output flags_t       dn_flags
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      dn_result <= up_result;
      dn_flags  <= up_flags;
    end
  end
endmodule

// File: rtl/dec_flag_unit.sv
module dec_flag_unit
  import dec_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_operand,
  input  logic [1:0]        in_size,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic [FLAG_W-1:0] out_flags
);
  opsz_e        sz;
  logic [W-1:0] lane_mask;
  logic [W-1:0] top_mask;
  logic [W-1:0] result;
  flags_t       fl_in;
  flags_t       fl_new;
  flags_t       fl_q;

  assign sz    = opsz_e'(in_size);
  assign fl_in = flags_t'(in_flags);

  dec_width_mask #(.W(W)) u_mask (
    .size      (sz),
    .lane_mask (lane_mask),
    .top_mask  (top_mask)
  );

  dec_core #(.W(W)) u_core (
    .operand   (in_operand),
    .size      (sz),
    .lane_mask (lane_mask),
    .result    (result)
  );

  dec_flag_gen #(.W(W)) u_flags (
    .operand   (in_operand),
    .result    (result),
    .lane_mask (lane_mask),
    .top_mask  (top_mask),
    .flags_in  (fl_in),
    .flags_out (fl_new)
  );

  dec_out_stage #(.W(W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .up_valid  (in_valid),
    .up_ready  (in_ready),
    .up_result (result),
    .up_flags  (fl_new),
    .dn_valid  (out_valid),
    .dn_ready  (out_ready),
    .dn_result (out_result),
    .dn_flags  (fl_q)
  );

  assign out_flags = fl_q;
endmodule

// File: rtl/dec_flag_unit_chk.sv
module dec_flag_unit_chk
  import dec_flag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [W-1:0]      in_operand,
  input logic [1:0]        in_size,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_result,
  input logic [FLAG_W-1:0] out_flags
);
  logic       cry_q;
  logic [1:0] size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cry_q  <= 1'b0;
      size_q <= 2'd0;
    end else if (in_valid && in_ready) begin
      cry_q  <= in_flags[0];
      size_q <= in_size;
    end
  end

  a_r11_reset_clear: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  a_r9_accept_to_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  a_r3_carry_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_flags[0] == cry_q));

  a_r8_low_byte_parity: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_flags[1] == ~^out_result[7:0]));

  a_r2_upper_cleared: assert property (@(posedge clk) disable iff (rst)
    (out_valid && size_q == 2'd2) |-> (out_result[63:32] == 32'd0));
endmodule

bind dec_flag_unit dec_flag_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_operand (in_operand),
  .in_size    (in_size),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/dec_flag_unit_test.sv
module dec_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_size = '0;
  logic [5:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [5:0]  out_flags;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  dec_flag_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_size(in_size), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent reference, written per size
  task automatic model(input logic [63:0] op, input logic [1:0] sz, input logic [5:0] fi,
                       output logic [63:0] r, output logic [5:0] fo);
    logic ovf, sgn, zro;
    case (sz)
      2'd0: begin r = {op[63:8],  op[7:0]  - 8'd1};
                  ovf = op[7:0] == 8'h80; sgn = r[7];  zro = r[7:0] == 0; end
      2'd1: begin r = {op[63:16], op[15:0] - 16'd1};
                  ovf = op[15:0] == 16'h8000; sgn = r[15]; zro = r[15:0] == 0; end
      2'd2: begin r = {32'd0, op[31:0] - 32'd1};
                  ovf = op[31:0] == 32'h8000_0000; sgn = r[31]; zro = r[31:0] == 0; end
      default: begin r = op - 64'd1;
                  ovf = op == 64'h8000_0000_0000_0000; sgn = r[63]; zro = r == 0; end
    endcase
    fo = {ovf, sgn, zro, op[3:0] == 4'd0, ($countones(r[7:0]) % 2) == 0, fi[0]};
  endtask

  task automatic check_out(logic [63:0] op, logic [1:0] sz, logic [5:0] fi);
    logic [63:0] er;
    logic [5:0]  ef;
    model(op, sz, fi, er, ef);
    check("R9 out_valid", 64'(out_valid), 64'd1);
    check("R1/R2 result", out_result, er);
    check("R3 carry", 64'(out_flags[0]), 64'(ef[0]));
    check("R8 parity", 64'(out_flags[1]), 64'(ef[1]));
    check("R7 aux", 64'(out_flags[2]), 64'(ef[2]));
    check("R6 zero", 64'(out_flags[3]), 64'(ef[3]));
    check("R5 sign", 64'(out_flags[4]), 64'(ef[4]));
    check("R4 overflow", 64'(out_flags[5]), 64'(ef[5]));
  endtask

  task automatic drive(logic [63:0] op, logic [1:0] sz, logic [5:0] fi);
    in_valid = 1'b1; in_operand = op; in_size = sz; in_flags = fi;
  endtask

  task automatic send_one(logic [63:0] op, logic [1:0] sz, logic [5:0] fi);
    @(negedge clk);
    drive(op, sz, fi);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(op, sz, fi);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 out_valid after reset", 64'(out_valid), 64'd0);
    check("R9 in_ready when empty", 64'(in_ready), 64'd1);
  endtask

  task automatic t_sizes;
    send_one(64'hAAAA_BBBB_CCCC_DD12, 2'd0, 6'h00);
    send_one(64'hAAAA_BBBB_CCCC_DD80, 2'd0, 6'h3F);  // R4 byte
    send_one(64'h1111_2222_3333_4400, 2'd0, 6'h01);  // R7, wrap
    send_one(64'hFFFF_FFFF_FFFF_FF01, 2'd0, 6'h00);  // R6 zero
    send_one(64'h5555_6666_7777_8000, 2'd1, 6'h01);  // R4 half
    send_one(64'hDEAD_BEEF_0000_0001, 2'd2, 6'h00);  // R2 clear, R6
    send_one(64'hDEAD_BEEF_8000_0000, 2'd2, 6'h01);  // R4 word
    send_one(64'h0000_0000_0000_0000, 2'd3, 6'h00);  // R5 sign
    send_one(64'h8000_0000_0000_0000, 2'd3, 6'h01);  // R4 full
    send_one(64'h0123_4567_89AB_CDE7, 2'd3, 6'h3E);  // R3 carry clear
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    drive(64'h0000_0000_0000_0050, 2'd0, 6'h01);
    @(negedge clk);
    drive(64'h0000_0000_0000_0300, 2'd1, 6'h00);
    check("R9 in_ready low when full and stalled", 64'(in_ready), 64'd0);
    @(negedge clk);
    check_out(64'h50, 2'd0, 6'h01);  // R10 held across stall
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(64'h300, 2'd1, 6'h00);  // second taken after release
  endtask

  task automatic t_burst;
    @(negedge clk);
    drive(64'h10, 2'd0, 6'h00);
    @(negedge clk);
    check_out(64'h10, 2'd0, 6'h00);
    drive(64'hFFFF, 2'd1, 6'h01);
    @(negedge clk);
    check_out(64'hFFFF, 2'd1, 6'h01);
    drive(64'h1, 2'd3, 6'h00);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(64'h1, 2'd3, 6'h00);
    @(negedge clk);
    check("R9 out_valid drops when idle", 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    out_ready = 1'b0;
    drive(64'h77, 2'd0, 6'h00);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset clears pending result", 64'(out_valid), 64'd0);
    out_ready = 1'b1;
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sizes();
    t_stall();
    t_burst();
    t_reset_mid();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule